// File: doc/BRIEF.md
# Fixed-Order External Interrupt Claim Controller

This block gathers up to 31 level-sensitive interrupt sources for a single hart and presents them through a claim/complete register. Sources are numbered 1 to 31; number 0 means "nothing". Selection is fixed: the lowest-numbered source that is active and not already being serviced wins. The block has no priority levels, per-source enables, thresholds or extra contexts.

Software reads the claim register to learn which source to service. That read also marks the source as in service, so it no longer raises the interrupt. When the handler finishes, it writes the same number back, and the source becomes eligible again. Both the machine-level and supervisor-level external interrupt lines are driven from one condition: some source is active and not in service.

The register port is a 32-bit valid/ready request channel with a one-deep response channel. A request is taken on the cycle where `req_valid` and `req_ready` are both high. Exactly one response follows, on the next cycle. While a response is waiting and `rsp_ready` is low, the response is held unchanged and `req_ready` stays low, so no further request is taken.

Top module: `irq_claim_ctrl`

## Requirements
- R1: Source n (1..31) is wired to bit n-1 of `src_level`. A claim that selects it returns the number n.
- R2: The internal active state of each source copies `src_level` on every clock edge. A source whose level drops stops counting as active after the next edge.
- R3: A word read of offset 0x200004 returns the lowest source number that is active and not in service, and marks that source as in service at the same handshake. If no source qualifies, the read returns 0 and changes nothing.
- R4: A word write of value v to offset 0x200004 takes a source out of service when 1 <= v <= 31. Writes of v = 0 or v >= 32 have no effect.
- R5: `irq_m_ext` and `irq_s_ext` are always equal. They are high exactly when at least one source is active and not in service.
- R6: Reading offset 0x200000 returns 0. Any other offset reads 0 and ignores writes. Any access whose `req_size` is not 2'b10 (32-bit) reads 0 and has no side effect.
- R7: A claim acts once per request handshake. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds and `req_ready` is low.
- R8: When a claim and a change of `src_level` fall in the same cycle, the claim uses the active state registered before that cycle.
- R9: Reset clears both the active state and the in-service state of every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte offset inside the block |
| req_size | input | 2 | Access size; 2'b10 = 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| src_level | input | 31 | Interrupt source levels, bit n-1 = source n |
| irq_m_ext | output | 1 | Machine external interrupt |
| irq_s_ext | output | 1 | Supervisor external interrupt |

## Verification
Random source vectors are mixed with claims, completions and stray accesses. Dense vectors test the lowest-wins rule, while sparse and empty vectors separate a correct zero return from a stale one. Completion values cover the bounds 1 and 31, the ignored values 0, 32 and larger, and numbers that are not in service. These values separate a correct range check from a bit index that wraps around. Directed cases test the response held under back-pressure, a claim in the same cycle as a source change, and a reset that falls while a source is in service.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic       found;
    logic [4:0] num;
  } claim_pick_t;
endpackage

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler #(
  parameter int unsigned NSRC = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_level,
  output logic [NSRC-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src_level;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NSRC  = 31,
  parameter int unsigned NUM_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]  avail,
  output logic             found,
  output logic [NUM_W-1:0] num,
  output logic [NSRC-1:0]  onehot
);
  logic [NSRC:0] below_any;
  assign below_any[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign onehot[i]      = avail[i] & ~below_any[i];
    assign below_any[i+1] = below_any[i] | avail[i];
  end

  assign found = below_any[NSRC];

  always_comb begin
    num = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (onehot[i]) num = num | NUM_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_served_track.sv
module irq_served_track #(
  parameter int unsigned NSRC  = 31,
  parameter int unsigned NUM_W = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [NSRC-1:0] set_onehot,
  input  logic            clr_en,
  input  logic [31:0]     clr_value,
  output logic [NSRC-1:0] serv_q
);
  logic            clr_ok;
  logic [31:0]     clr_idx;
  logic [NSRC-1:0] clr_mask;

  assign clr_idx = clr_value - 32'd1;
  assign clr_ok  = clr_en && (clr_value != 32'd0) && (clr_value <= 32'(NSRC));

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (clr_ok && clr_idx == 32'(i)) clr_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) serv_q <= '0;
    else if (set_en) serv_q <= serv_q | set_onehot;
    else             serv_q <= serv_q & ~clr_mask;
  end
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int unsigned NSRC      = 31,
  parameter int unsigned ADDR_W    = 22,
  parameter logic [21:0] BASE_OFF  = 22'h200000,
  parameter logic [21:0] CLAIM_OFF = 22'h200004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic [NSRC-1:0]   src_level,
  output logic              irq_m_ext,
  output logic              irq_s_ext
);
  import irq_claim_pkg::*;
  localparam int unsigned NUM_W = $clog2(NSRC + 1);

  logic [NSRC-1:0]  pend_q, serv_q, avail, pick_oh;
  logic             pick_found;
  logic [NUM_W-1:0] pick_num;
  logic             take, is_word, hit_claim, claim_fire, cmpl_fire;
  logic             base_rd;

  irq_pend_sampler #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .pend_q(pend_q)
  );

  assign avail = pend_q & ~serv_q;

  irq_lowest_pick #(.NSRC(NSRC), .NUM_W(NUM_W)) u_pick (
    .avail(avail), .found(pick_found), .num(pick_num), .onehot(pick_oh)
  );

  assign req_ready  = !rsp_valid || rsp_ready;
  assign take       = req_valid && req_ready;
  assign is_word    = (req_size == SIZE_WORD);
  assign hit_claim  = is_word && (req_addr == CLAIM_OFF[ADDR_W-1:0]);
  assign base_rd    = is_word && (req_addr == BASE_OFF[ADDR_W-1:0]);
  assign claim_fire = take && !req_write && hit_claim;
  assign cmpl_fire  = take &&  req_write && hit_claim;

  irq_served_track #(.NSRC(NSRC), .NUM_W(NUM_W)) u_serv (
    .clk(clk), .rst_n(rst_n),
    .set_en(claim_fire && pick_found), .set_onehot(pick_oh),
    .clr_en(cmpl_fire), .clr_value(req_wdata),
    .serv_q(serv_q)
  );

  // base offset reads zero like every unmapped offset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      if (claim_fire && pick_found) rsp_rdata <= DATA_W'(pick_num);
      else if (base_rd)             rsp_rdata <= '0;
      else                          rsp_rdata <= '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign irq_m_ext = |avail;
  assign irq_s_ext = |avail;
endmodule

// File: rtl/irq_claim_ctrl_chk.sv
module irq_claim_ctrl_chk #(
  parameter int unsigned NSRC      = 31,
  parameter int unsigned ADDR_W    = 22,
  parameter logic [21:0] CLAIM_OFF = 22'h200004
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [NSRC-1:0]   src_level,
  input logic              irq_m_ext,
  input logic              irq_s_ext
);
  logic claim_hs, other_rd_hs;
  assign claim_hs    = req_valid && req_ready && !req_write &&
                       req_size == 2'b10 && req_addr == CLAIM_OFF[ADDR_W-1:0];
  assign other_rd_hs = req_valid && req_ready && !req_write && !claim_hs;

  assert_out_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_m_ext == irq_s_ext);

  assert_claim_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata <= 32'(NSRC));

  assert_empty_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_hs && !irq_m_ext) |=> rsp_valid && rsp_rdata == 32'd0);

  assert_no_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_level == '0) |=> !irq_m_ext);

  assert_other_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    other_rd_hs |=> rsp_rdata == 32'd0);

  assert_hold_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  assert_stall_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind irq_claim_ctrl irq_claim_ctrl_chk #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .CLAIM_OFF(CLAIM_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .src_level(src_level), .irq_m_ext(irq_m_ext), .irq_s_ext(irq_s_ext)
);

// File: tb/irq_claim_ctrl_tb.sv
module irq_claim_ctrl_tb;
  localparam int NSRC = 31;
  localparam logic [21:0] CLM = 22'h200004;
  localparam logic [21:0] BAS = 22'h200000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic [NSRC-1:0] src_level = '0;
  logic req_ready, rsp_valid, irq_m_ext, irq_s_ext;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  logic [NSRC-1:0] pend_m = '0, serv_m = '0;

  always #5 clk = ~clk;

  irq_claim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .src_level(src_level),
    .irq_m_ext(irq_m_ext), .irq_s_ext(irq_s_ext)
  );

  function automatic logic [31:0] exp_claim(logic [NSRC-1:0] p, logic [NSRC-1:0] s);
    for (int i = 0; i < NSRC; i++) if (p[i] && !s[i]) return 32'(i + 1);
    return 32'd0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    e = |(pend_m & ~serv_m);
    chk(irq_m_ext == e && irq_s_ext == e, tag, {30'd0, irq_s_ext, irq_m_ext}, {30'd0, e, e});
  endtask

  task automatic set_src(input logic [NSRC-1:0] v);
    @(negedge clk); src_level = v;
    @(negedge clk); pend_m = v;
  endtask

  // one request; response sampled at the next negedge
  task automatic bus(input logic wr, input logic [21:0] a, input logic [31:0] d,
                     input logic [1:0] sz, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
    chk(rsp_valid, "R7 response present", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic claim(input string tag);
    logic [31:0] e, rd;
    e = exp_claim(pend_m, serv_m);
    bus(0, CLM, 0, 2'b10, rd);
    if (e != 0) serv_m[e-1] = 1'b1;
    chk(rd == e, tag, rd, e);
  endtask

  task automatic complete(input logic [31:0] v);
    logic [31:0] rd;
    bus(1, CLM, v, 2'b10, rd);
    if (v >= 1 && v <= NSRC) serv_m[v-1] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; src_level = '0;
    repeat (2) @(negedge clk);
    rst_n = 1; pend_m = '0; serv_m = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd, e;
    void'($urandom(32'd2024));
    do_reset();
    chk(!irq_m_ext && !irq_s_ext && !rsp_valid, "R9 reset state", {31'd0, irq_m_ext}, 0);
    claim("R3 empty claim returns 0");

    // R1 / R3 lowest wins and numbering
    set_src(31'h4000_0001 | 31'h0000_0100);
    chk_irq("R5 irq on");
    claim("R1 source 1 first");
    claim("R3 next lowest 9");
    claim("R1 source 31");
    claim("R3 all served returns 0");
    chk_irq("R5 irq off when all served");
    // R4 ignored values
    complete(0); complete(32); complete(33); complete(32'hFFFF_FFFF);
    chk_irq("R4 bad completions ignored");
    complete(31);
    chk_irq("R4 complete 31");
    claim("R4 source 31 reclaimed");
    complete(1); complete(9); complete(31);
    // R2 level drop
    set_src(31'h0000_0100);
    chk_irq("R2 pending follows level");
    claim("R2 only 9 remains");
    complete(9);
    // R6 other offsets and sizes
    bus(0, BAS, 0, 2'b10, rd);
    chk(rd == 0, "R6 base offset reads 0", rd, 0);
    bus(0, CLM, 0, 2'b01, rd);
    chk(rd == 0, "R6 narrow claim reads 0", rd, 0);
    chk_irq("R6 narrow claim no side effect");
    bus(1, 22'h000010, 32'd9, 2'b10, rd);
    bus(0, 22'h000010, 0, 2'b10, rd);
    chk(rd == 0, "R6 other offset reads 0", rd, 0);
    claim("R6 stray accesses left state alone");
    complete(9);

    // R8 claim coincides with source change
    set_src(31'h0000_0004);
    e = exp_claim(pend_m, serv_m);
    @(negedge clk);
    src_level = 31'h0000_0001;
    req_valid = 1; req_write = 0; req_addr = CLM; req_size = 2'b10;
    @(negedge clk);
    req_valid = 0; rd = rsp_rdata;
    pend_m = 31'h0000_0001; serv_m[e-1] = 1'b1;
    chk(rd == e, "R8 claim uses registered pending", rd, e);
    claim("R8 new source visible next");
    complete(1); complete(3);

    // R7 back-pressure
    do_reset();
    set_src(31'h0000_0006);
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = CLM; req_size = 2'b10;
    @(negedge clk);
    serv_m[1] = 1'b1;
    chk(rsp_valid && rsp_rdata == 2, "R7 first claim", rsp_rdata, 2);
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready && rsp_rdata == 2, "R7 held under back-pressure", rsp_rdata, 2);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    serv_m[2] = 1'b1;
    chk(rsp_valid && rsp_rdata == 3, "R7 second claim once", rsp_rdata, 3);
    @(negedge clk);
    chk_irq("R7 both served");

    // R9 reset clears served
    set_src(31'h0000_0010);
    claim("R9 claim before reset");
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; pend_m = '0; serv_m = '0;
    chk(!irq_m_ext, "R9 pending cleared", {31'd0, irq_m_ext}, 0);
    @(negedge clk); pend_m = src_level;
    claim("R9 served cleared by reset");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) begin
        logic [NSRC-1:0] v;
        v = NSRC'($urandom) & NSRC'($urandom);
        set_src(v);
      end else if (op < 6) begin
        claim("R3 random claim");
      end else if (op < 9) begin
        logic [31:0] v;
        if ($urandom_range(0, 3) != 0) v = 32'($urandom_range(1, NSRC));
        else v = $urandom_range(0, 1) ? 32'($urandom_range(32, 40)) : 32'd0;
        complete(v);
      end else begin
        bus(0, 22'($urandom_range(0, 255)) << 2, 0, 2'b10, rd);
        if (req_addr != CLM) chk(rd == 0, "R6 random offset", rd, 0);
        else begin
          e = exp_claim(pend_m, serv_m);
          if (e != 0) serv_m[e-1] = 1'b1;
          chk(rd == e, "R3 random hit", rd, e);
        end
      end
      chk_irq("R5 random irq");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule